// File: doc/BRIEF.md
# Read-Transfer Handshake Bridge

This block links two four-phase handshakes for read transfers. On the bus side a requester raises a strobe and waits for an acknowledge. On the device side the block raises its own strobe toward a peripheral and waits for that peripheral's acknowledge. Between the two it asserts a latch enable, which opens the read data path toward the bus. The block is a clocked synchronous machine. Both handshake inputs pass through a synchronizer chain before the machine sees them.

The device-side return to zero is allowed to overlap the next bus request. A fresh request can therefore arrive while the device strobe and acknowledge are both still high. The visible signal code in that moment matches the code seen just before the latch enable rises. A hidden phase bit tells the two apart. It is set when the latch enable rises and cleared when the device strobe drops. While the bit is set, the block drops the device strobe and does not open the latch.

Any synchronized input edge that the protocol does not permit in the current phase raises a sticky error flag. From then on every output holds its value until reset.

Top module: `rd_handshake_ctrl`

## Requirements
- R1: After reset, bus_ack_o, dev_strobe_o, latch_en_o and proto_err_o are all 0.
- R2: The rising half runs in a fixed order. dev_strobe_o rises only after bus_req_i is seen high. latch_en_o rises only while dev_strobe_o and dev_ack_i are both high. bus_ack_o rises only while latch_en_o is high.
- R3: The falling half runs in a fixed order. latch_en_o falls only after bus_req_i is seen low while bus_ack_o is high. bus_ack_o falls on the next clock edge. dev_strobe_o falls STROBE_LAG clock edges after bus_ack_o falls.
- R4: An input change reaches the machine after SYNC_STAGES rising edges (default 2). A resulting output change appears on the following edge, which is the third rising edge after the input change by default.
- R5: A new bus request can be seen during the device return window, while dev_strobe_o and dev_ack_i are still high. In that case dev_strobe_o still falls on schedule and latch_en_o stays low until a fresh device handshake completes.
- R6: dev_strobe_o rises again only after dev_ack_i has been seen low.
- R7: The following synchronized edges are illegal:
  - bus_req_i rises while bus_ack_o or latch_en_o is high;
  - bus_req_i falls while bus_ack_o is low;
  - dev_ack_i rises other than in the phase where the device strobe is raised and the hidden phase bit is clear;
  - dev_ack_i falls while dev_strobe_o is high.

  Any illegal edge sets proto_err_o to 1 on the edge where the machine sees it.
- R8: Once proto_err_o is 1, it stays 1 and bus_ack_o, dev_strobe_o and latch_en_o keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus-side read strobe request (asynchronous) |
| dev_ack_i | input | 1 | Device-side acknowledge (asynchronous) |
| bus_ack_o | output | 1 | Bus-side data acknowledge |
| dev_strobe_o | output | 1 | Device-side strobe |
| latch_en_o | output | 1 | Read data latch enable |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bound checker watches the edge ordering of both halves of the handshake on every cycle. It checks that the device strobe re-arms only on a low acknowledge, that the hidden phase bit keeps the latch shut in the overlapping return state, and that the error state freezes. Exact latencies are shown only by the bench's scenarios, together with the STROBE_LAG delay before the strobe drops and the overlapped back-to-back request. Those scenarios also show that each class of illegal edge really raises the flag. The bench's behavioural phase model compares every output on each clock.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

  localparam int IDX_REQ = 0;
  localparam int IDX_ACK = 1;
  localparam int N_IN    = 2;

  typedef struct packed {
    logic dtack;   // bus acknowledge
    logic lds;     // device strobe
    logic d;       // latch enable
    logic csc;     // hidden phase bit: set with latch, cleared with strobe drop
  } hs_state_t;

  localparam hs_state_t HS_RESET = '{dtack: 1'b0, lds: 1'b0, d: 1'b0, csc: 1'b0};

  // Legality of synchronized input edges for a given state.
  function automatic logic req_rise_ok(hs_state_t s);
    return !s.dtack && !s.d;
  endfunction

  function automatic logic req_fall_ok(hs_state_t s);
    return s.dtack;
  endfunction

  function automatic logic ack_rise_ok(hs_state_t s);
    return s.lds && !s.csc;
  endfunction

  function automatic logic ack_fall_ok(hs_state_t s);
    return !s.lds;
  endfunction

  // Device return window: strobe still high, phase bit set, bus side released.
  function automatic logic in_return(hs_state_t s);
    return s.lds && s.csc && !s.d && !s.dtack;
  endfunction

  // One step of the handshake machine.
  function automatic hs_state_t hs_step(hs_state_t s, logic req, logic ack,
                                        logic lag_done);
    hs_state_t n;
    n = s;
    if (req && !ack && !s.lds && !s.csc && !s.d && !s.dtack)
      n.lds = 1'b1;
    if (req && ack && s.lds && !s.csc && !s.d && !s.dtack) begin
      n.d   = 1'b1;
      n.csc = 1'b1;
    end
    if (req && s.d && !s.dtack)
      n.dtack = 1'b1;
    if (!req && s.d && s.dtack)
      n.d = 1'b0;
    if (s.dtack && !s.d && s.csc)
      n.dtack = 1'b0;
    if (lag_done) begin
      n.lds = 1'b0;
      n.csc = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rdhs_edge.sv
module rdhs_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/rdhs_guard.sv
module rdhs_guard
  import rdhs_pkg::*;
(
  input  hs_state_t st_i,
  input  logic      req_rise_i,
  input  logic      req_fall_i,
  input  logic      ack_rise_i,
  input  logic      ack_fall_i,
  output logic      bad_o
);
  logic bad_req_up, bad_req_dn, bad_ack_up, bad_ack_dn;

  assign bad_req_up = req_rise_i && !req_rise_ok(st_i);
  assign bad_req_dn = req_fall_i && !req_fall_ok(st_i);
  assign bad_ack_up = ack_rise_i && !ack_rise_ok(st_i);
  assign bad_ack_dn = ack_fall_i && !ack_fall_ok(st_i);
  assign bad_o      = bad_req_up || bad_req_dn || bad_ack_up || bad_ack_dn;
endmodule

// File: rtl/rdhs_lag_timer.sv
module rdhs_lag_timer #(
  parameter int LAG = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (LAG > 1) ? $clog2(LAG) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAG - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rd_handshake_ctrl.sv
module rd_handshake_ctrl
  import rdhs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_LAG  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_i,
  input  logic dev_ack_i,
  output logic bus_ack_o,
  output logic dev_strobe_o,
  output logic latch_en_o,
  output logic proto_err_o
);
  logic [N_IN-1:0] raw_in, syn_in, in_rise, in_fall;
  logic req_s, ack_s;
  hs_state_t st_q, st_d;
  logic err_q, bad_evt, lag_en, lag_done;
  logic csc_w;

  assign raw_in[IDX_REQ] = bus_req_i;
  assign raw_in[IDX_ACK] = dev_ack_i;

  rdhs_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in));

  assign req_s = syn_in[IDX_REQ];
  assign ack_s = syn_in[IDX_ACK];

  rdhs_edge #(.WIDTH(N_IN)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(syn_in), .rise_o(in_rise), .fall_o(in_fall));

  rdhs_guard u_guard (
    .st_i(st_q),
    .req_rise_i(in_rise[IDX_REQ]), .req_fall_i(in_fall[IDX_REQ]),
    .ack_rise_i(in_rise[IDX_ACK]), .ack_fall_i(in_fall[IDX_ACK]),
    .bad_o(bad_evt));

  assign lag_en = in_return(st_q) && !err_q && !bad_evt;

  rdhs_lag_timer #(.LAG(STROBE_LAG)) u_lag (
    .clk(clk), .rst_n(rst_n), .en_i(lag_en), .done_o(lag_done));

  always_comb begin
    if (err_q || bad_evt) st_d = st_q;
    else                  st_d = hs_step(st_q, req_s, ack_s, lag_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HS_RESET;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_q || bad_evt;
    end
  end

  assign csc_w        = st_q.csc;
  assign bus_ack_o    = st_q.dtack;
  assign dev_strobe_o = st_q.lds;
  assign latch_en_o   = st_q.d;
  assign proto_err_o  = err_q;
endmodule

// File: rtl/rd_handshake_ctrl_chk.sv
module rd_handshake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_s,
  input logic ack_s,
  input logic dtack,
  input logic lds,
  input logic d,
  input logic csc,
  input logic err
);
  AST_STROBE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lds) |-> $past(req_s) && !$past(ack_s) && !$past(d) && !$past(dtack)); // R6
  AST_LATCH_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d) |-> $past(lds) && $past(ack_s) && $past(req_s)); // R2
  AST_ACK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack) |-> $past(d)); // R2
  AST_LATCH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(d) |-> !$past(req_s) && $past(dtack)); // R3
  AST_ACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack) |-> !$past(d) && $past(lds)); // R3
  AST_STROBE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lds) |-> !$past(dtack) && !$past(d)); // R3
  AST_PHASE_BLOCKS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (csc && lds && req_s && ack_s && !d) |=> !d); // R5
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && $stable(dtack) && $stable(lds) && $stable(d)); // R8
endmodule

bind rd_handshake_ctrl rd_handshake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_s(req_s), .ack_s(ack_s),
  .dtack(bus_ack_o), .lds(dev_strobe_o), .d(latch_en_o), .csc(csc_w),
  .err(proto_err_o));

// File: tb/rd_handshake_ctrl_bench.sv
`timescale 1ns/1ps
module rd_handshake_ctrl_bench;
  localparam int LAG = 3;
  localparam int PH_IDLE = 0, PH_STB = 1, PH_LAT = 2, PH_ACK = 3, PH_REL = 4, PH_RTZ = 5;

  logic clk = 0, rst_n = 0, req_drv = 0, ack_drv = 0;
  logic bus_ack_o, dev_strobe_o, latch_en_o, proto_err_o;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done_run = 0;
  bit dev_auto = 0;
  int dev_delay = 2, dev_cnt = 0;

  // reference model state
  int ph = PH_IDLE, lag_cnt = 0;
  bit m_err = 0, q_prev = 0, a_prev = 0;
  bit rq_pipe[$], ak_pipe[$];

  always #4 clk = ~clk;

  rd_handshake_ctrl #(.SYNC_STAGES(2), .STROBE_LAG(LAG)) u_rd_handshake_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req_i(req_drv), .dev_ack_i(ack_drv),
    .bus_ack_o(bus_ack_o), .dev_strobe_o(dev_strobe_o),
    .latch_en_o(latch_en_o), .proto_err_o(proto_err_o));

  function automatic bit m_lds(); return ph != PH_IDLE; endfunction
  function automatic bit m_d();   return ph == PH_LAT || ph == PH_ACK; endfunction
  function automatic bit m_ack(); return ph == PH_ACK || ph == PH_REL; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = PH_IDLE; lag_cnt = 0; m_err = 0; q_prev = 0; a_prev = 0;
      rq_pipe = '{0, 0}; ak_pipe = '{0, 0};
    end else begin
      bit rq, ak, bad;
      rq = rq_pipe[0]; ak = ak_pipe[0];
      if (!m_err) begin
        bad = 0;
        if (rq && !q_prev && !(ph == PH_IDLE || ph == PH_RTZ || ph == PH_STB)) bad = 1;
        if (!rq && q_prev && !(ph == PH_ACK || ph == PH_REL)) bad = 1;
        if (ak && !a_prev && ph != PH_STB) bad = 1;
        if (!ak && a_prev && ph != PH_IDLE) bad = 1;
        if (bad) m_err = 1;
        else case (ph)
          PH_IDLE: if (rq && !ak) ph = PH_STB;
          PH_STB:  if (rq && ak) ph = PH_LAT;
          PH_LAT:  if (rq) ph = PH_ACK;
          PH_ACK:  if (!rq) ph = PH_REL;
          PH_REL:  begin ph = PH_RTZ; lag_cnt = 0; end
          default: if (lag_cnt == LAG - 1) ph = PH_IDLE; else lag_cnt++;
        endcase
      end
      q_prev = rq; a_prev = ak;
      void'(rq_pipe.pop_front()); rq_pipe.push_back(req_drv);
      void'(ak_pipe.pop_front()); ak_pipe.push_back(ack_drv);
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      check(bus_ack_o == m_ack(), cur_req, "bus_ack", bus_ack_o, m_ack());
      check(dev_strobe_o == m_lds(), cur_req, "dev_strobe", dev_strobe_o, m_lds());
      check(latch_en_o == m_d(), cur_req, "latch_en", latch_en_o, m_d());
      check(proto_err_o == m_err, cur_req, "proto_err", proto_err_o, m_err);
    end
  end

  // autonomous device: follows its strobe after dev_delay cycles
  always @(posedge clk) begin
    #1;
    if (dev_auto) begin
      if (dev_strobe_o != ack_drv) begin
        dev_cnt++;
        if (dev_cnt >= dev_delay) begin ack_drv = dev_strobe_o; dev_cnt = 0; end
      end else dev_cnt = 0;
    end
  end

  task automatic finish_run();
    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic wait_ack(logic v, string tag);
    int n = 0;
    while (bus_ack_o !== v && n < 300) begin tick(); n++; end
    check(n < 300, tag, "wait bus_ack", n, 0);
  endtask

  task automatic wait_strobe(logic v, string tag);
    int n = 0;
    while (dev_strobe_o !== v && n < 300) begin tick(); n++; end
    check(n < 300, tag, "wait dev_strobe", n, 0);
  endtask

  task automatic do_reset();
    dev_auto = 0; req_drv = 0; ack_drv = 0;
    rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
  endtask

  task automatic frozen_check(string tag);
    logic a, s, l;
    a = bus_ack_o; s = dev_strobe_o; l = latch_en_o;
    check(proto_err_o == 1, tag, "err set", proto_err_o, 1);
    req_drv = ~req_drv; ack_drv = ~ack_drv;
    repeat (6) tick();
    check({bus_ack_o, dev_strobe_o, latch_en_o} == {a, s, l}, tag, "outputs frozen",
          {bus_ack_o, dev_strobe_o, latch_en_o}, {a, s, l});
    check(proto_err_o == 1, tag, "err sticky", proto_err_o, 1);
  endtask

  initial begin
    int n;
    do_reset();
    cur_req = "R1";
    check({bus_ack_o, dev_strobe_o, latch_en_o, proto_err_o} == 4'b0, "R1", "reset outputs",
          {bus_ack_o, dev_strobe_o, latch_en_o, proto_err_o}, 0);

    // R4 latency from request to device strobe
    cur_req = "R4"; dev_auto = 1; dev_delay = 2;
    req_drv = 1;
    tick(); check(dev_strobe_o == 0, "R4", "strobe after edge 1", dev_strobe_o, 0);
    tick(); check(dev_strobe_o == 0, "R4", "strobe after edge 2", dev_strobe_o, 0);
    tick(); check(dev_strobe_o == 1, "R4", "strobe after edge 3", dev_strobe_o, 1);

    // R2 rising order
    cur_req = "R2";
    wait_ack(1, "R2");
    check(latch_en_o == 1 && dev_strobe_o == 1, "R2", "latch and strobe with ack",
          {latch_en_o, dev_strobe_o}, 3);

    // R3 falling order and strobe lag
    cur_req = "R3";
    req_drv = 0;
    wait_ack(0, "R3");
    check(latch_en_o == 0, "R3", "latch low when ack drops", latch_en_o, 0);
    check(dev_strobe_o == 1, "R3", "strobe still high", dev_strobe_o, 1);
    n = 0;
    while (dev_strobe_o && n < 50) begin tick(); n++; end
    check(n == LAG, "R3", "cycles from ack fall to strobe fall", n, LAG);
    repeat (8) tick();

    // R5 overlapped request in the device return window
    cur_req = "R5"; dev_delay = 4;
    req_drv = 1; wait_ack(1, "R5"); req_drv = 0; wait_ack(0, "R5");
    req_drv = 1;
    wait_strobe(0, "R5");
    check(latch_en_o == 0, "R5", "latch closed at strobe drop", latch_en_o, 0);
    cur_req = "R6";
    tick();
    check(dev_strobe_o == 0, "R6", "no re-arm while ack high", dev_strobe_o, 0);
    wait_strobe(1, "R6");
    check(latch_en_o == 0, "R6", "latch closed at re-arm", latch_en_o, 0);
    cur_req = "R5";
    wait_ack(1, "R5");
    check(latch_en_o == 1, "R5", "fresh handshake completes", latch_en_o, 1);
    req_drv = 0; wait_ack(0, "R5"); wait_strobe(0, "R5");
    repeat (8) tick();

    // R7 request dropped before acknowledge
    cur_req = "R7"; dev_delay = 6;
    req_drv = 1; wait_strobe(1, "R7");
    req_drv = 0; dev_auto = 0;
    repeat (4) tick();
    cur_req = "R8"; frozen_check("R8");

    // R7 acknowledge without strobe
    do_reset(); cur_req = "R7";
    ack_drv = 1; repeat (4) tick();
    check(proto_err_o == 1, "R7", "stray device ack", proto_err_o, 1);

    // R7 acknowledge dropped while strobe high
    do_reset(); cur_req = "R7";
    req_drv = 1; wait_strobe(1, "R7");
    ack_drv = 1; n = 0;
    while (!latch_en_o && n < 50) begin tick(); n++; end
    ack_drv = 0; repeat (4) tick();
    cur_req = "R8"; frozen_check("R8");

    do_reset(); cur_req = "R1";
    check({bus_ack_o, dev_strobe_o, latch_en_o, proto_err_o} == 4'b0, "R1", "reset clears error",
          {bus_ack_o, dev_strobe_o, latch_en_o, proto_err_o}, 0);
    finish_run();
  end
endmodule